// File: doc/BRIEF.md
# Traceback Survivor Memory Controller

This block sits behind the add-compare-select array of a convolutional decoder. Each trellis step delivers one decision bit per state, and the block stores those bits in a decision memory of four rotating banks of `L` stages each. It recovers the transmitted data by walking survivor paths backwards through the stored decisions. Three accesses share each step. A write stores the new decision vector. A traceback walks the two newest complete banks, two stages per step, from a start state supplied at the start of each bank period. A decode walk covers the oldest bank, starting from the state where the previous traceback ended, and emits one decoded bit per step.

The decode walk produces bits newest-first. A pair of ping-pong last-in-first-out buffers, each `L` bits deep, restores forward time order. The stream leaves on `out_bit`, qualified by `out_valid`, at a fixed distance of `5*L` accepted steps behind the input. The write address of each bank reverses direction on every reuse. Because of this, every step writes exactly the location that the decode walk reads in that same step.

Top module: `surv_trace_mem`

## Requirements
- R1: On each cycle with `step_valid` high, bit `s` of `dec_vec` is stored as the decision of state `s` for that trellis step. States are numbered so that the newest data bit is the state LSB and the oldest is the MSB.
- R2: A traceback starts from `tb_start_state`, which is sampled only on the first valid step of each `L`-step period. That value is the state after the last accepted step.
- R3: The predecessor of state `s` with decision `d` is `{~d, s[K-2:1]}`: decision 1 selects the predecessor whose MSB is 0. The decode walk starts from the state where the previous traceback ended, and each decoded bit is the LSB of the visited state (even gives 0, odd gives 1).
- R4: Decoded bits leave in forward time order: the n-th `out_valid` pulse carries the data bit of the n-th accepted step.
- R5: The bit of accepted step t appears, with `out_valid`, in the cycle after accepted step t+5L. No `out_valid` occurs during the first 5L accepted steps.
- R6: On a cycle with `step_valid` low, nothing advances, and `out_valid` is low in the following cycle.
- R7: While `rst_n` is low, `out_valid` and `out_bit` are 0.
- R8: The memory holds exactly 4L stages. Each step's write reuses the location that the decode walk reads in that step, and decoding stays correct across many reuses of every bank.
- R9: `K` must be at least 3 and `L` must be even and at least 2. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A new trellis step is presented |
| dec_vec | input | 2**(K-1) | Decision bit of every state for this step |
| tb_start_state | input | K-1 | State after the last accepted step, traceback origin |
| out_bit | output | 1 | Decoded bit in forward order |
| out_valid | output | 1 | `out_bit` is valid this cycle |

## Verification
Every result depends on counting accepted steps, not clock cycles. A decoded bit is due one cycle after the accepted step that lies 5L steps after its source step. The bench keeps its own step and output counters and, 1 ns after each rising edge, checks both the bit value and the step distance of every pulse. Idle cycles are checked in the cycle right after them for a silent `out_valid`. During warm-up, every step without output is checked against the 5L bound. The start state is driven with random values on all but period-opening steps, so a sampling error shows up in the decoded data.

// File: rtl/surv_trace_pkg.sv
package surv_trace_pkg;
   localparam int unsigned NUM_BANKS = 4;
   localparam int unsigned PER_W     = 3;

   // Period tag: low two bits select the bank, bit 2 gives its address direction
   typedef logic [PER_W-1:0] period_t;

   function automatic logic [1:0] bank_of(input period_t p);
      return p[1:0];
   endfunction

   function automatic logic dir_of(input period_t p);
      return p[2];
   endfunction
endpackage

// File: rtl/surv_trace_seq.sv
module surv_trace_seq
   import surv_trace_pkg::*;
#(
   parameter int L = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   output logic [SW-1:0]        step,
   output period_t              period,
   output logic                 warm
);
   localparam int SW     = (L > 1) ? $clog2(L) : 1;
   localparam int WARM_P = 5;

   logic [2:0] warm_cnt;
   logic       wrap;

   assign wrap = (step == SW'(L - 1));
   assign warm = (warm_cnt == 3'(WARM_P));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step     <= '0;
         period   <= '0;
         warm_cnt <= '0;
      end else if (adv) begin
         if (wrap) begin
            step   <= '0;
            period <= period + 1'b1;
            if (!warm) warm_cnt <= warm_cnt + 1'b1;
         end else begin
            step <= step + 1'b1;
         end
      end
   end

   // R6
   seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(step) && $stable(period)));

   // R8
   seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap) |=> (step == '0 && period == $past(period) + 1'b1));

   // R5
   warm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |=> warm);
endmodule

// File: rtl/surv_trace_decmem.sv
module surv_trace_decmem
   import surv_trace_pkg::*;
#(
   parameter int SB  = 10,
   parameter int L   = 16,
   parameter int NRD = 3
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [1:0]               wr_bank,
   input  logic [SW-1:0]            wr_idx,
   input  logic [NS-1:0]            wr_data,
   input  logic [NRD-1:0][1:0]      rd_bank,
   input  logic [NRD-1:0][SW-1:0]   rd_idx,
   input  logic [NRD-1:0][SB-1:0]   rd_sel,
   output logic [NRD-1:0]           rd_bit
);
   localparam int NS    = 1 << SB;
   localparam int SW    = (L > 1) ? $clog2(L) : 1;
   localparam int DEPTH = NUM_BANKS * L;
   localparam int AW    = $clog2(DEPTH);

   logic [NS-1:0] mem [DEPTH];
   logic [AW-1:0] wr_addr;

   assign wr_addr = AW'(wr_bank) * AW'(L) + AW'(wr_idx);

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [AW-1:0] addr;
      assign addr      = AW'(rd_bank[r]) * AW'(L) + AW'(rd_idx[r]);
      assign rd_bit[r] = mem[addr][rd_sel[r]];
   end
endmodule

// File: rtl/surv_trace_lifo.sv
module surv_trace_lifo #(
   parameter int L = 16
) (
   input  logic          clk,
   input  logic          adv,
   input  logic          half,
   input  logic [SW-1:0] step,
   input  logic          in_bit,
   output logic          out_bit
);
   localparam int SW = (L > 1) ? $clog2(L) : 1;

   logic [L-1:0] buf_q [2];
   logic [SW-1:0] rd_pos;

   assign rd_pos = SW'(L - 1) - step;

   for (genvar h = 0; h < 2; h++) begin : g_half
      always_ff @(posedge clk) begin
         if (adv && (half == 1'(h))) buf_q[h][step] <= in_bit;
      end
   end

   assign out_bit = buf_q[~half][rd_pos];
endmodule

// File: rtl/surv_trace_mem.sv
module surv_trace_mem
   import surv_trace_pkg::*;
#(
   parameter int K = 11,
   parameter int L = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step_valid,
   input  logic [(1<<(K-1))-1:0] dec_vec,
   input  logic [K-2:0]          tb_start_state,
   output logic                  out_bit,
   output logic                  out_valid
);
   localparam int SB = K - 1;
   localparam int NS = 1 << SB;
   localparam int SW = (L > 1) ? $clog2(L) : 1;

   // R9
   if (K < 3) begin : g_bad_k
      $error("surv_trace_mem: K must be at least 3");
   end
   if (L < 2 || (L % 2) != 0) begin : g_bad_l
      $error("surv_trace_mem: L must be even and at least 2");
   end

   function automatic logic [SB-1:0] pred(input logic [SB-1:0] s, input logic d);
      return {~d, s[SB-1:1]};
   endfunction

   function automatic logic [SW-1:0] off_idx(input logic dir, input int off);
      return dir ? SW'(L - 1 - off) : SW'(off);
   endfunction

   logic [SW-1:0] step;
   period_t       period;
   logic          warm;

   surv_trace_seq #(.L(L)) u_seq (
      .clk(clk), .rst_n(rst_n), .adv(step_valid),
      .step(step), .period(period), .warm(warm)
   );

   // Walk state
   logic [SB-1:0] tb_state, dc_state;
   logic [SB-1:0] tb_cur, tb_mid, tb_nxt, dc_cur, dc_nxt;
   logic          first;

   assign first = (step == '0);

   // Address generation
   logic [1:0]    wr_bank;
   logic [SW-1:0] wr_idx, dc_idx, tb_idx0, tb_idx1;
   period_t       tb_per;
   logic          tb_half;
   int            tb_off0;

   assign tb_half = int'(step) >= (L / 2);
   assign tb_per  = period - (tb_half ? 3'd2 : 3'd1);
   assign wr_bank = bank_of(period);

   always_comb begin
      wr_idx  = off_idx(dir_of(period), int'(step));
      dc_idx  = off_idx(~dir_of(period), L - 1 - int'(step));
      tb_off0 = (tb_half ? (2 * L - 1) : (L - 1)) - 2 * int'(step);
      tb_idx0 = off_idx(dir_of(tb_per), tb_off0);
      tb_idx1 = off_idx(dir_of(tb_per), tb_off0 - 1);
   end

   logic [2:0][1:0]    rd_bank;
   logic [2:0][SW-1:0] rd_idx;
   logic [2:0][SB-1:0] rd_sel;
   logic [2:0]         rd_bit;

   assign tb_cur = first ? tb_start_state : tb_state;
   assign dc_cur = first ? tb_state : dc_state;
   assign tb_mid = pred(tb_cur, rd_bit[0]);
   assign tb_nxt = pred(tb_mid, rd_bit[1]);
   assign dc_nxt = pred(dc_cur, rd_bit[2]);

   assign rd_bank[0] = bank_of(tb_per);
   assign rd_bank[1] = bank_of(tb_per);
   assign rd_bank[2] = bank_of(period);
   assign rd_idx[0]  = tb_idx0;
   assign rd_idx[1]  = tb_idx1;
   assign rd_idx[2]  = dc_idx;
   assign rd_sel[0]  = tb_cur;
   assign rd_sel[1]  = tb_mid;
   assign rd_sel[2]  = dc_cur;

   surv_trace_decmem #(.SB(SB), .L(L), .NRD(3)) u_mem (
      .clk(clk), .wr_en(step_valid), .wr_bank(wr_bank), .wr_idx(wr_idx),
      .wr_data(dec_vec), .rd_bank(rd_bank), .rd_idx(rd_idx),
      .rd_sel(rd_sel), .rd_bit(rd_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tb_state <= '0;
         dc_state <= '0;
      end else if (step_valid) begin
         tb_state <= tb_nxt;
         dc_state <= dc_nxt;
      end
   end

   // Bit-order reversal
   logic rev_bit;

   surv_trace_lifo #(.L(L)) u_rev (
      .clk(clk), .adv(step_valid), .half(period[0]), .step(step),
      .in_bit(dc_cur[0]), .out_bit(rev_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= step_valid && warm;
         if (step_valid && warm) out_bit <= rev_bit;
      end
   end

   // R8
   addr_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |-> (wr_idx == dc_idx));

   // R5
   no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(warm));

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> !out_valid);
endmodule

// File: tb/surv_trace_mem_bench.sv
module surv_trace_mem_bench;
   localparam int K     = 5;
   localparam int L     = 4;
   localparam int SB    = K - 1;
   localparam int NS    = 1 << SB;
   localparam int LAT   = 5 * L;
   localparam int NSTEP = 600;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          step_valid = 1'b0;
   logic [NS-1:0] dec_vec = '0;
   logic [SB-1:0] tb_start_state = '0;
   logic          out_bit, out_valid;

   always #4 clk = ~clk;

   surv_trace_mem #(.K(K), .L(L)) u_surv_trace_mem (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .dec_vec(dec_vec),
      .tb_start_state(tb_start_state), .out_bit(out_bit), .out_valid(out_valid)
   );

   int n_cmp = 0, n_bad = 0;
   int steps = 0, outs = 0;
   bit done = 1'b0;
   logic src [NSTEP];
   logic [SB-1:0] ts = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // One clock: present a step (or an idle cycle) and check the registered outputs
   task automatic do_step(input bit v, input bit u);
      logic [SB-1:0] ns;
      ns = {ts[SB-2:0], u};
      @(negedge clk);
      step_valid = v;
      dec_vec    = NS'($urandom);
      // R2: start state matters only at the period opening step
      tb_start_state = (v && (steps % L == 0)) ? ts : SB'($urandom);
      if (v) begin
         dec_vec[ns] = ~ts[SB-1];   // R1 R3: decision 1 means predecessor MSB 0
         src[steps]  = u;
      end
      @(posedge clk);
      #1;
      if (v) begin
         ts = ns;
         steps++;
      end
      if (!v) begin
         chk(out_valid == 1'b0, "R6 idle cycle pulse", int'(out_valid), 0);
      end else if (out_valid) begin
         chk(out_bit == src[outs], "R3 R4 decoded bit", int'(out_bit), int'(src[outs]));
         chk(steps - 1 == outs + LAT, "R5 step distance", steps - 1 - outs, LAT);
         outs++;
      end else begin
         chk(steps - 1 < LAT, "R5 missing pulse after warm-up", steps - 1, LAT - 1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
      chk(out_bit == 1'b0, "R7 reset bit", int'(out_bit), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NSTEP; i++) begin
         bit u;
         if (i < 48)       u = 1'b0;
         else if (i < 96)  u = 1'b1;
         else if (i < 144) u = 1'(i % 2);
         else              u = 1'($urandom);
         if (i >= 144 && (i % 7) == 3) do_step(1'b0, 1'b0);
         if (i >= 300 && (i % 11) == 5) do_step(1'b0, 1'b0);
         do_step(1'b1, u);
      end

      // R8: every bank reused many times; full output count proves no lost stage
      chk(outs == NSTEP - LAT, "R8 R4 output count", outs, NSTEP - LAT);

      @(negedge clk);
      step_valid = 1'b1;
      rst_n      = 1'b0;
      @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R7 mid-run reset valid", int'(out_valid), 0);
      chk(out_bit == 1'b0, "R7 mid-run reset bit", int'(out_bit), 0);
      @(negedge clk);
      step_valid = 1'b0;
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", steps, NSTEP);
         report();
         $finish;
      end
   end
endmodule